// File: doc/BRIEF.md
# Bus-Attached Serial Port with Queues

This block is a byte-wide serial port that a processor reaches through a Wishbone slave port with a 12-bit address. Bytes written by software go into a transmit queue. A transmitter empties that queue onto `txd_o` as asynchronous frames with one start bit, eight data bits and one stop bit. A receiver rebuilds frames from `rxd_i` and stores them in a receive queue, and software drains that queue through a data register. Both queues have the same parameterised depth.

A divisor register sets the bit rate. An internal tick fires once every divisor+1 clocks, and each bit lasts sixteen ticks. The `irq_o` output is asserted while any enabled condition holds. One condition is "receive queue holds data" and the other is "transmit queue is empty". This lets the port be driven by interrupts or by polling.

Top module: `sport_wb`

## Requirements
- R1: Registers decode on the full 12-bit address: 0x000 transmit data (write), 0x008 receive data (read), 0x010 status (read), 0x018 divisor (read/write), 0x020 interrupt enables (read/write). A read from any other address, or a read of 0x000, returns 0x00. A write to any address other than 0x000, 0x018 and 0x020 changes no state.
- R2: A cycle is accepted when cyc and stb are high while the bus side is idle. The registered acknowledge rises on the next edge and stays set until stb goes low. `wb_ack_o` is that registered acknowledge ANDed with cyc and stb. Each accepted cycle performs exactly one register access, however long stb is held.
- R3: Status bit 0 is receive queue empty, bit 1 is transmit queue empty, bit 2 is receive queue full and bit 3 is transmit queue full. Bits 7:4 read as 0.
- R4: After the synchronous active-low reset, the divisor and both interrupt enables are 0. The divisor reads back all 8 written bits. The enable register keeps data bits 1:0 only and reads 0 in bits 7:2.
- R5: A write to 0x000 appends the byte to the transmit queue. The byte is dropped when the queue is full.
- R6: A read of 0x008 removes and returns the oldest received byte. It returns 0x00 when the queue is empty.
- R7: `txd_o` idles high. A frame is a low start bit, eight data bits LSB first, then a high stop bit. Each bit lasts 16×(divisor+1) clocks.
- R8: `rxd_i` passes through two flip-flops. A start bit is confirmed 8 ticks after the falling level is seen. Data bits are then sampled every 16 ticks, LSB first.
- R9: A frame whose stop bit samples low is discarded. After such a frame the receiver waits for the line to go high before it looks for a new start bit.
- R10: A byte that arrives while the receive queue is full is discarded, and the stored bytes are left unchanged.
- R11: `irq_o` = (enable bit 0 AND receive queue not empty) OR (enable bit 1 AND transmit queue empty). It is 0 during reset.
- R12: Queue depth is the parameter `DEPTH` (default 64). The full flag asserts when DEPTH bytes are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wb_adr_i | input | 12 | Bus byte address |
| wb_dat_i | input | 8 | Bus write data |
| wb_dat_o | output | 8 | Bus read data, valid with acknowledge |
| wb_we_i | input | 1 | Write enable |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_ack_o | output | 1 | Acknowledge |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every one of the 4096 addresses for reads and writes. A decoder that matched only some address bits would alias the registers, and the sweep would then see non-zero reads or a changed divisor. Each queue is filled past its depth. A design that overwrote data or wrapped its count would then return a fifth byte or lose the first. A read is held with strobe high for several cycles and the next byte is checked afterwards. A design that popped on every cycle of the hold would skip a byte. A frame with a low stop bit is followed straight away by a good frame. A receiver that did not wait for the line to go high would store a stray 0xFF or lose the good byte. Frames are also run at a divisor of 1, which catches a bit period that ignores the divisor.

// File: rtl/sport_pkg.sv
// Shared constants and state types for the serial port.
// Assumes: byte-wide bus, 12-bit byte addresses, register spacing of 8.
package sport_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_TXDATA = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RXDATA = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DIVISOR = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_IRQEN = 12'h020;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_ACK
    } bus_state_e;
endpackage

// File: rtl/sport_fifo.sv
// Synchronous first-in first-out byte queue.
// Assumes: push when full and pop when empty are ignored; read data is the
// oldest entry, presented combinationally whenever the queue is not empty.
module sport_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == CW'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rdata_o = mem[rd_ptr];

    // Purpose: store an accepted byte.
    always_ff @(posedge clk_i) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    // Purpose: advance pointers and track occupancy.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count <= CW'(DEPTH));
    assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && push_i && !pop_i) |=> full_o);
endmodule

// File: rtl/sport_tick.sv
// Oversampling tick generator: one tick every div_i+1 clocks.
// Assumes: divisor may change at any time; a counter above it restarts.
module sport_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;

    assign tick_o = (cnt >= div_i);

    // Purpose: count clocks between ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sport_tx.sv
// Frame transmitter: start bit, W data bits LSB first, stop bit.
// Assumes: takes a byte the cycle it is idle and data is available; each
// bit lasts OVS ticks.
module sport_tx #(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         avail_i,
    input  logic [W-1:0] data_i,
    output logic         pop_o,
    output logic         txd_o
);
    localparam int FRAME = W + 2;
    localparam int BW    = $clog2(FRAME + 1);
    localparam int TW    = $clog2(OVS);
    localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(FRAME - 1);

    logic             busy;
    logic [FRAME-1:0] shift;
    logic [BW-1:0]    bit_cnt;
    logic [TW-1:0]    tick_cnt;

    assign pop_o = !busy && avail_i;
    assign txd_o = busy ? shift[0] : 1'b1;

    // Purpose: load a frame and shift it out one bit per OVS ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy     <= 1'b0;
            shift    <= '1;
            bit_cnt  <= '0;
            tick_cnt <= '0;
        end else if (pop_o) begin
            busy     <= 1'b1;
            shift    <= {1'b1, data_i, 1'b0};
            bit_cnt  <= '0;
            tick_cnt <= '0;
        end else if (busy && tick_i) begin
            if (tick_cnt == T_LAST) begin
                tick_cnt <= '0;
                shift    <= {1'b1, shift[FRAME-1:1]};
                if (bit_cnt == B_LAST) busy <= 1'b0;
                else                   bit_cnt <= bit_cnt + 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assert_start_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> !txd_o);
endmodule

// File: rtl/sport_rx.sv
// Frame receiver with two-flop synchroniser and mid-bit sampling.
// Assumes: OVS ticks per bit; a frame with a low stop bit is dropped and
// the line must return high before the next start is sought.
module sport_rx #(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         rxd_i,
    output logic         push_o,
    output logic [W-1:0] data_o
);
    import sport_pkg::*;

    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(W);
    localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
    localparam logic [TW-1:0] T_HALF = TW'(OVS / 2 - 1);
    localparam logic [BW-1:0] B_LAST = BW'(W - 1);

    logic          sync1, rx_s;
    rx_state_e     state;
    logic [TW-1:0] tick_cnt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  shift;

    assign data_o = shift;

    // Purpose: bring the asynchronous line into the clock domain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync1 <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            sync1 <= rxd_i;
            rx_s  <= sync1;
        end
    end

    // Purpose: walk the frame and emit a one-cycle push on a valid stop bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state    <= RX_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            shift    <= '0;
            push_o   <= 1'b0;
        end else begin
            push_o <= 1'b0;
            case (state)
                RX_IDLE: if (tick_i && !rx_s) begin
                    state    <= RX_START;
                    tick_cnt <= '0;
                end
                RX_START: if (tick_i) begin
                    if (tick_cnt == T_HALF) begin
                        tick_cnt <= '0;
                        bit_cnt  <= '0;
                        state    <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick_i) begin
                    if (tick_cnt == T_LAST) begin
                        tick_cnt <= '0;
                        shift    <= {rx_s, shift[W-1:1]};
                        if (bit_cnt == B_LAST) state <= RX_STOP;
                        else                   bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick_i) begin
                    if (tick_cnt == T_LAST) begin
                        tick_cnt <= '0;
                        if (rx_s) begin
                            push_o <= 1'b1;
                            state  <= RX_IDLE;
                        end else begin
                            state  <= RX_HOLD;
                        end
                    end else begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                RX_HOLD: if (rx_s) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    assert_hold_no_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == RX_HOLD) |-> !push_o);
    assert_push_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_o |=> !push_o);
endmodule

// File: rtl/sport_wb.sv
// Serial port top: Wishbone register decode, two queues, transmitter,
// receiver and interrupt logic.
// Assumes: one register access per accepted cycle; acknowledge is held
// until strobe drops; reset is synchronous and active low.
module sport_wb #(
    parameter int DEPTH = 64,
    parameter int OVS   = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [11:0] wb_adr_i,
    input  logic [7:0]  wb_dat_i,
    output logic [7:0]  wb_dat_o,
    input  logic        wb_we_i,
    input  logic        wb_cyc_i,
    input  logic        wb_stb_i,
    output logic        wb_ack_o,
    output logic        txd_o,
    input  logic        rxd_i,
    output logic        irq_o
);
    import sport_pkg::*;

    bus_state_e          bus_state;
    logic                ack_r;
    logic [DATA_W-1:0]   dat_r;
    logic [DATA_W-1:0]   div_r;
    logic [1:0]          ie_r;
    logic                accept, tx_push, rx_pop;
    logic                tick;
    logic [DATA_W-1:0]   tx_head, rx_head, rx_byte;
    logic                tx_empty, tx_full, rx_empty, rx_full;
    logic                tx_pop, rx_push;

    assign accept   = (bus_state == BUS_IDLE) && wb_cyc_i && wb_stb_i;
    assign tx_push  = accept && wb_we_i && (wb_adr_i == OFS_TXDATA);
    assign rx_pop   = accept && !wb_we_i && (wb_adr_i == OFS_RXDATA);
    assign wb_ack_o = ack_r && wb_cyc_i && wb_stb_i;
    assign wb_dat_o = dat_r;
    assign irq_o    = rst_ni && ((ie_r[0] && !rx_empty) || (ie_r[1] && tx_empty));

    // Purpose: bus handshake, register writes and read-data capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bus_state <= BUS_IDLE;
            ack_r     <= 1'b0;
            dat_r     <= '0;
            div_r     <= '0;
            ie_r      <= '0;
        end else if (bus_state == BUS_IDLE) begin
            if (accept) begin
                ack_r     <= 1'b1;
                bus_state <= BUS_ACK;
                dat_r     <= '0;
                if (wb_we_i) begin
                    if (wb_adr_i == OFS_DIVISOR) div_r <= wb_dat_i;
                    if (wb_adr_i == OFS_IRQEN)   ie_r  <= wb_dat_i[1:0];
                end else begin
                    case (wb_adr_i)
                        OFS_RXDATA:  dat_r <= rx_empty ? '0 : rx_head;
                        OFS_STATUS:  dat_r <= {4'b0, tx_full, rx_full, tx_empty, rx_empty};
                        OFS_DIVISOR: dat_r <= div_r;
                        OFS_IRQEN:   dat_r <= {6'b0, ie_r};
                        default:     dat_r <= '0;
                    endcase
                end
            end
        end else if (!wb_stb_i) begin
            ack_r     <= 1'b0;
            bus_state <= BUS_IDLE;
        end
    end

    sport_tick #(.DIV_W(DATA_W)) tick_i (
        .clk_i (clk_i), .rst_ni(rst_ni), .div_i(div_r), .tick_o(tick)
    );

    sport_fifo #(.DEPTH(DEPTH), .W(DATA_W)) txq_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tx_push), .wdata_i(wb_dat_i),
        .pop_i(tx_pop), .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full)
    );

    sport_fifo #(.DEPTH(DEPTH), .W(DATA_W)) rxq_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push), .wdata_i(rx_byte),
        .pop_i(rx_pop), .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full)
    );

    sport_tx #(.W(DATA_W), .OVS(OVS)) tx_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .avail_i(!tx_empty),
        .data_i(tx_head), .pop_o(tx_pop), .txd_o(txd_o)
    );

    sport_rx #(.W(DATA_W), .OVS(OVS)) rx_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_i),
        .push_o(rx_push), .data_o(rx_byte)
    );

    assert_ack_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_r && wb_stb_i) |=> ack_r);
    assert_single_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_pop |=> !rx_pop);
    assert_irq_enabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (ie_r != 2'b00));
endmodule

// File: tb/sport_wb_tb_top.sv
`timescale 1ns/1ps
module sport_wb_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] adr = '0;
    logic [7:0]  wdat = '0;
    logic [7:0]  rdat;
    logic        we = 1'b0, cyc = 1'b0, stb = 1'b0;
    logic        ack, txd, irq;
    logic        rxd = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    int bit_clks = 16;
    logic [7:0] tx_log [0:15];
    int  tx_cnt = 0;
    int  tx_badstop = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    sport_wb #(.DEPTH(DEPTH), .OVS(16)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wb_adr_i(adr), .wb_dat_i(wdat),
        .wb_dat_o(rdat), .wb_we_i(we), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_ack_o(ack), .txd_o(txd), .rxd_i(rxd), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        adr = a; wdat = d; we = 1'b1; cyc = 1'b1; stb = 1'b1;
        do @(negedge clk); while (!ack);
        cyc = 1'b0; stb = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        adr = a; we = 1'b0; cyc = 1'b1; stb = 1'b1;
        do @(negedge clk); while (!ack);
        d = rdat;
        cyc = 1'b0; stb = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bit_clks) @(negedge clk);
        end
        rxd = stop;
        repeat (bit_clks) @(negedge clk);
        rxd = 1'b1;
        repeat (bit_clks) @(negedge clk);
    endtask

    // Serial monitor on txd: decodes frames at mid-bit.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                automatic int bc = bit_clks;
                automatic logic [7:0] b = '0;
                repeat (bc / 2) @(negedge clk);
                for (int i = 0; i < 8; i++) begin
                    repeat (bc) @(negedge clk);
                    b[i] = txd;
                end
                repeat (bc) @(negedge clk);
                if (txd !== 1'b1) tx_badstop++;
                if (tx_cnt < 16) tx_log[tx_cnt] = b;
                tx_cnt++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, e;
        logic [7:0] tx_pat [0:5];
        logic [7:0] rx_pat [0:4];
        tx_pat = '{8'h55, 8'h00, 8'hFF, 8'h81, 8'h3C, 8'h99};
        rx_pat = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R7 txd idle", {7'b0, txd}, 8'h01);
        chk("R11 irq reset", {7'b0, irq}, 8'h00);
        chk("R2 ack idle", {7'b0, ack}, 8'h00);
        bus_read(12'h010, v); chk("R3 status reset", v, 8'h03);
        bus_read(12'h018, v); chk("R4 divisor reset", v, 8'h00);
        bus_read(12'h020, v); chk("R4 enable reset", v, 8'h00);

        // R4: divisor sweep and enable mask.
        for (int d = 0; d < 256; d++) begin
            bus_write(12'h018, 8'(d));
            bus_read(12'h018, v);
            chk("R4 divisor readback", v, 8'(d));
        end
        bus_write(12'h020, 8'hFF); bus_read(12'h020, v); chk("R4 enable mask", v, 8'h03);

        // R1: full address read sweep.
        bus_write(12'h018, 8'h5A);
        bus_write(12'h020, 8'h01);
        for (int a = 0; a < 4096; a++) begin
            case (a)
                12'h010: e = 8'h03;
                12'h018: e = 8'h5A;
                12'h020: e = 8'h01;
                default: e = 8'h00;
            endcase
            bus_read(12'(a), v);
            chk("R1 read decode", v, e);
        end
        // R1: writes elsewhere change nothing.
        for (int a = 1; a < 4096; a++) begin
            if (a != 12'h018 && a != 12'h020) bus_write(12'(a), 8'hFF);
        end
        bus_read(12'h018, v); chk("R1 divisor untouched", v, 8'h5A);
        bus_read(12'h020, v); chk("R1 enable untouched", v, 8'h01);
        bus_read(12'h010, v); chk("R1 status after writes", v, 8'h03);
        @(negedge clk); chk("R1 no stray tx", {7'b0, txd}, 8'h01);
        bus_write(12'h018, 8'h00);

        // R11: interrupt enables with both queues empty.
        bus_write(12'h020, 8'h02); @(negedge clk); chk("R11 tx-empty irq", {7'b0, irq}, 8'h01);
        bus_write(12'h020, 8'h01); @(negedge clk); chk("R11 rx-empty no irq", {7'b0, irq}, 8'h00);
        bus_write(12'h020, 8'h02);

        // R5/R7/R12: transmit overflow.
        for (int i = 0; i < 6; i++) bus_write(12'h000, tx_pat[i]);
        bus_read(12'h010, v); chk("R5 R12 tx full status", v, 8'h09);
        @(negedge clk); chk("R11 irq off while tx busy", {7'b0, irq}, 8'h00);
        repeat (1200) @(negedge clk);
        chk("R5 tx frame count", 8'(tx_cnt), 8'd5);
        for (int i = 0; i < 5; i++) chk("R7 tx byte", tx_log[i], tx_pat[i]);
        chk("R7 tx stop bits", 8'(tx_badstop), 8'd0);
        bus_read(12'h010, v); chk("R3 status drained", v, 8'h03);
        chk("R11 irq tx empty again", {7'b0, irq}, 8'h01);

        // R8/R10: receive overflow.
        bus_write(12'h020, 8'h00);
        for (int i = 0; i < 5; i++) send_frame(rx_pat[i], 1'b1);
        bus_read(12'h010, v); chk("R10 R12 rx full status", v, 8'h06);
        bus_write(12'h020, 8'h01); @(negedge clk); chk("R11 rx irq", {7'b0, irq}, 8'h01);
        bus_write(12'h020, 8'h00); @(negedge clk); chk("R11 rx irq disabled", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            bus_read(12'h008, v); chk("R8 R10 rx byte", v, rx_pat[i]);
        end
        bus_read(12'h008, v); chk("R6 empty read zero", v, 8'h00);
        bus_read(12'h010, v); chk("R3 rx empty again", v, 8'h03);

        // R9: bad stop bit, then recovery.
        send_frame(8'h33, 1'b0);
        bus_read(12'h010, v); chk("R9 bad frame dropped", v, 8'h03);
        send_frame(8'hC6, 1'b1);
        bus_read(12'h008, v); chk("R9 next frame received", v, 8'hC6);
        bus_read(12'h010, v); chk("R9 no stray byte", v, 8'h03);

        // R2: held acknowledge, gating and single pop.
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        @(negedge clk);
        adr = 12'h008; we = 1'b0; cyc = 1'b1; stb = 1'b1;
        #1 chk("R2 no early ack", {7'b0, ack}, 8'h00);
        @(negedge clk);
        chk("R2 ack rises", {7'b0, ack}, 8'h01);
        chk("R6 held read data", rdat, 8'h11);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); chk("R2 ack held", {7'b0, ack}, 8'h01);
        end
        cyc = 1'b0; #1 chk("R2 ack gated by cyc", {7'b0, ack}, 8'h00);
        cyc = 1'b1; #1 chk("R2 ack restored", {7'b0, ack}, 8'h01);
        @(negedge clk);
        stb = 1'b0; cyc = 1'b0;
        @(negedge clk); chk("R2 ack released", {7'b0, ack}, 8'h00);
        bus_read(12'h008, v); chk("R2 one pop per cycle", v, 8'h22);

        // R7/R8: divisor 1 doubles bit period.
        bus_write(12'h018, 8'h01);
        bit_clks = 32;
        send_frame(8'h81, 1'b1);
        bus_read(12'h008, v); chk("R8 rx at divisor 1", v, 8'h81);
        tx_cnt = 0;
        bus_write(12'h000, 8'h7E);
        repeat (450) @(negedge clk);
        chk("R7 tx count at divisor 1", 8'(tx_cnt), 8'd1);
        chk("R7 tx byte at divisor 1", tx_log[0], 8'h7E);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule